// File: doc/BRIEF.md
# Frequency Lock Monitor and Phase Detector Selector

This block watches a clock recovered from serial data, after division, and compares its rate with a local reference clock. It counts recovered-clock cycles across a fixed window of reference cycles. From that count it decides whether the recovering loop is close enough in frequency to be trusted. It then selects which phase detector steers the oscillator. A phase-frequency detector pulls the loop in during acquisition. A bang-bang detector holds the sampling point once the frequency is close.

A two-bit strap picks one of four behaviours. Two of them are automatic, each with its own tolerance window. The other two pin the selection to one detector. The reference may run at either of two rates that differ by a factor of four, chosen by a separate strap. The expected count and the tolerance scale with that rate. The measured count crosses from the recovered-clock domain into the reference domain through a toggle request/acknowledge exchange.

Lock is declared only after two consecutive good windows. A single bad window removes it. This keeps the detector selection from flapping near the edge of the tolerance window.

Top module: `ppm_lock_detector`

## Requirements
- R1: While reset is asserted and just after it is released, `lock_ok` is 0 and `det_sel` is 0, which selects the phase-frequency detector.
- R2: With `mode_sel` = 2'b00 the block runs automatically with the narrow tolerance `TOL_NARROW`. It drives `det_sel` = 1 (bang-bang) while `lock_ok` is 1 and `det_sel` = 0 (phase-frequency) while `lock_ok` is 0.
- R3: With `mode_sel` = 2'b01 the block runs automatically in the same way, but with the wide tolerance `TOL_WIDE`.
- R4: With `mode_sel` = 2'b10, `det_sel` is held at 0. `lock_ok` still reports the result of the narrow-tolerance comparison.
- R5: With `mode_sel` = 2'b11, `det_sel` is held at 1. `lock_ok` still reports the result of the narrow-tolerance comparison.
- R6: A window lasts 2^`WIN_LOG2` reference cycles. The expected count of recovered cycles per window is 2^`WIN_LOG2` when `ref_rate_sel` = 1 (fast reference) and four times that when `ref_rate_sel` = 0 (slow reference). The tolerance is also multiplied by four when `ref_rate_sel` = 0. A window is in range when |count − expected| ≤ tolerance.
- R7: The first completed window after reset is discarded. `lock_ok` rises only on a measurement that is in range and that directly follows another in-range measurement.
- R8: A single out-of-range measurement clears `lock_ok` in the next reference cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all control logic runs on it |
| rec_clk | input | 1 | Divided recovered clock being measured |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each clock domain |
| mode_sel | input | 2 | Strap: 00 auto narrow, 01 auto wide, 10 force phase-frequency, 11 force bang-bang |
| ref_rate_sel | input | 1 | Strap: 1 fast reference (×1 expected count), 0 slow reference (×4) |
| lock_ok | output | 1 | High when in lock; low when the frequency is outside the selected window |
| det_sel | output | 1 | Detector selection: 0 phase-frequency, 1 bang-bang |

## Verification
The bench builds the block with `WIN_LOG2` = 6, `TOL_NARROW` = 2 and `TOL_WIDE` = 8. A window then lasts 64 reference cycles, so the whole sweep fits in a short run. The sweep covers every mode at both reference rates. For each case the recovered period is chosen so that the expected count is on target, between the narrow and wide limits, or beyond both. The lock and selection outcomes are computed from those periods. The short window also makes the acquisition timing after reset observable at a known cycle. A lock on a single good window, instead of two, would show up there.

// File: rtl/ppm_lock_pkg.sv
package ppm_lock_pkg;

  typedef enum logic [1:0] {
    MODE_AUTO_NARROW = 2'b00,
    MODE_AUTO_WIDE   = 2'b01,
    MODE_FORCE_PFD   = 2'b10,
    MODE_FORCE_BB    = 2'b11
  } lock_mode_e;

  localparam logic DET_PFD = 1'b0;
  localparam logic DET_BB  = 1'b1;

endpackage

// File: rtl/ppm_sync2.sv
module ppm_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/ppm_rst_sync.sv
module ppm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];

endmodule

// File: rtl/ppm_rec_sampler.sv
// Recovered-clock side: free-running cycle counter, snapshot on each request toggle.
module ppm_rec_sampler #(
  parameter int CNT_W = 20
) (
  input  logic             rec_clk,
  input  logic             rst_n,
  input  logic             req_tgl_i,
  output logic [CNT_W-1:0] snap_o,
  output logic             ack_tgl_o
);

  logic             req_s;
  logic             req_prev_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] snap_q, snap_d;
  logic             ack_q, ack_d;
  logic             capture;

  ppm_sync2 #(.W(1)) u_req_sync (
    .clk  (rec_clk),
    .rst_n(rst_n),
    .d    (req_tgl_i),
    .q    (req_s)
  );

  assign capture = req_s ^ req_prev_q;

  always_comb begin
    cnt_d  = cnt_q + CNT_W'(1);
    snap_d = snap_q;
    ack_d  = ack_q;
    if (capture) begin
      snap_d = cnt_q;
      ack_d  = ~ack_q;
    end
  end

  always_ff @(posedge rec_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      snap_q     <= '0;
      ack_q      <= 1'b0;
      req_prev_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      snap_q     <= snap_d;
      ack_q      <= ack_d;
      req_prev_q <= req_s;
    end
  end

  assign snap_o    = snap_q;
  assign ack_tgl_o = ack_q;

endmodule

// File: rtl/ppm_lock_eval.sv
// Reference side: window timing, count differencing, tolerance compare, lock hysteresis.
module ppm_lock_eval
  import ppm_lock_pkg::*;
#(
  parameter int WIN_LOG2   = 16,
  parameter int CNT_W      = 20,
  parameter int TOL_NARROW = 33,
  parameter int TOL_WIDE   = 131
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lock_mode_e       mode_i,
  input  logic             rate_hi_i,
  input  logic [CNT_W-1:0] snap_i,
  input  logic             ack_tgl_i,
  output logic             req_tgl_o,
  output logic             locked_o,
  output logic             meas_valid_o,
  output logic             in_range_o
);

  localparam logic [CNT_W-1:0] EXP_FAST = CNT_W'(1) << WIN_LOG2;
  localparam logic [CNT_W-1:0] EXP_SLOW = EXP_FAST << 2;
  localparam logic [CNT_W-1:0] TOLN_FAST = CNT_W'(TOL_NARROW);
  localparam logic [CNT_W-1:0] TOLW_FAST = CNT_W'(TOL_WIDE);
  localparam logic [CNT_W-1:0] TOLN_SLOW = TOLN_FAST << 2;
  localparam logic [CNT_W-1:0] TOLW_SLOW = TOLW_FAST << 2;

  logic [WIN_LOG2-1:0] win_q;
  logic                win_end;
  logic                req_q, req_d;
  logic                ack_s, ack_prev_q;
  logic                meas;
  logic                primed_q, primed_d;
  logic [CNT_W-1:0]    prev_q, prev_d;
  logic [CNT_W-1:0]    diff, dev, exp_cnt, tol;
  logic                wide_sel, in_range, meas_valid;
  logic                locked_q, locked_d;
  logic                run_q, run_d;

  ppm_sync2 #(.W(1)) u_ack_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ack_tgl_i),
    .q    (ack_s)
  );

  assign win_end = &win_q;
  assign meas    = ack_s ^ ack_prev_q;

  always_comb begin
    wide_sel = (mode_i == MODE_AUTO_WIDE);
    exp_cnt  = rate_hi_i ? EXP_FAST : EXP_SLOW;
    if (rate_hi_i) tol = wide_sel ? TOLW_FAST : TOLN_FAST;
    else           tol = wide_sel ? TOLW_SLOW : TOLN_SLOW;
    diff     = snap_i - prev_q;
    dev      = (diff >= exp_cnt) ? (diff - exp_cnt) : (exp_cnt - diff);
    in_range = (dev <= tol);
    meas_valid = meas && primed_q;
  end

  always_comb begin
    req_d    = win_end ? ~req_q : req_q;
    primed_d = primed_q | meas;
    prev_d   = meas ? snap_i : prev_q;
    locked_d = locked_q;
    run_d    = run_q;
    if (meas_valid) begin
      if (!in_range) begin
        locked_d = 1'b0;
        run_d    = 1'b0;
      end else if (run_q) begin
        locked_d = 1'b1;
      end else begin
        run_d    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q      <= '0;
      req_q      <= 1'b0;
      ack_prev_q <= 1'b0;
      primed_q   <= 1'b0;
      prev_q     <= '0;
      locked_q   <= 1'b0;
      run_q      <= 1'b0;
    end else begin
      win_q      <= win_q + WIN_LOG2'(1);
      req_q      <= req_d;
      ack_prev_q <= ack_s;
      primed_q   <= primed_d;
      prev_q     <= prev_d;
      locked_q   <= locked_d;
      run_q      <= run_d;
    end
  end

  assign req_tgl_o    = req_q;
  assign locked_o     = locked_q;
  assign meas_valid_o = meas_valid;
  assign in_range_o   = in_range;

endmodule

// File: rtl/ppm_lock_detector.sv
module ppm_lock_detector
  import ppm_lock_pkg::*;
#(
  parameter int WIN_LOG2   = 16,
  parameter int TOL_NARROW = 33,
  parameter int TOL_WIDE   = 131
) (
  input  logic       ref_clk,
  input  logic       rec_clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       ref_rate_sel,
  output logic       lock_ok,
  output logic       det_sel
);

  localparam int CNT_W = WIN_LOG2 + 4;

  logic             ref_rst_n, rec_rst_n;
  logic [2:0]       strap_s;
  lock_mode_e       mode_s;
  logic             rate_hi;
  logic             req_tgl, ack_tgl;
  logic [CNT_W-1:0] snap;
  logic             locked, meas_valid, in_range;
  logic             det_q, det_d;

  ppm_rst_sync u_ref_rst (.clk(ref_clk), .arst_n(rst_n), .rst_n_o(ref_rst_n));
  ppm_rst_sync u_rec_rst (.clk(rec_clk), .arst_n(rst_n), .rst_n_o(rec_rst_n));

  ppm_sync2 #(.W(3)) u_strap_sync (
    .clk  (ref_clk),
    .rst_n(ref_rst_n),
    .d    ({mode_sel, ref_rate_sel}),
    .q    (strap_s)
  );

  assign mode_s  = lock_mode_e'(strap_s[2:1]);
  assign rate_hi = strap_s[0];

  ppm_rec_sampler #(.CNT_W(CNT_W)) u_sampler (
    .rec_clk  (rec_clk),
    .rst_n    (rec_rst_n),
    .req_tgl_i(req_tgl),
    .snap_o   (snap),
    .ack_tgl_o(ack_tgl)
  );

  ppm_lock_eval #(
    .WIN_LOG2  (WIN_LOG2),
    .CNT_W     (CNT_W),
    .TOL_NARROW(TOL_NARROW),
    .TOL_WIDE  (TOL_WIDE)
  ) u_eval (
    .clk         (ref_clk),
    .rst_n       (ref_rst_n),
    .mode_i      (mode_s),
    .rate_hi_i   (rate_hi),
    .snap_i      (snap),
    .ack_tgl_i   (ack_tgl),
    .req_tgl_o   (req_tgl),
    .locked_o    (locked),
    .meas_valid_o(meas_valid),
    .in_range_o  (in_range)
  );

  always_comb begin
    case (mode_s)
      MODE_FORCE_PFD: det_d = DET_PFD;
      MODE_FORCE_BB:  det_d = DET_BB;
      default:        det_d = locked ? DET_BB : DET_PFD;
    endcase
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) det_q <= DET_PFD;
    else            det_q <= det_d;
  end

  assign det_sel = det_q;
  assign lock_ok = locked;

endmodule

// File: rtl/ppm_lock_checker.sv
module ppm_lock_checker (
  input logic       ref_clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       lock_ok,
  input logic       det_sel,
  input logic       meas_valid,
  input logic       in_range
);

  // R4
  a_r4_force_pfd: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (mode == 2'b10) |=> !det_sel);

  // R5
  a_r5_force_bb: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (mode == 2'b11) |=> det_sel);

  // R2
  a_r2_pfd_unlocked: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!mode[1] && !lock_ok) |=> !det_sel);

  // R2
  a_r2_bb_locked: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!mode[1] && lock_ok) |=> det_sel);

  // R7
  a_r7_lock_on_good: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(lock_ok) |-> $past(meas_valid && in_range));

  // R8
  a_r8_drop_on_bad: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (meas_valid && !in_range) |=> !lock_ok);

endmodule

bind ppm_lock_detector ppm_lock_checker u_chk (
  .ref_clk   (ref_clk),
  .rst_n     (ref_rst_n),
  .mode      (strap_s[2:1]),
  .lock_ok   (lock_ok),
  .det_sel   (det_sel),
  .meas_valid(meas_valid),
  .in_range  (in_range)
);

// File: tb/ppm_lock_detector_tb.sv
`timescale 1ns/1ps
module ppm_lock_detector_tb;

  localparam int WL   = 6;
  localparam int TOLN = 2;
  localparam int TOLW = 8;
  localparam int WIN  = 1 << WL;

  logic       ref_clk = 1'b0;
  logic       rec_clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_sel;
  logic       ref_rate_sel;
  logic       lock_ok;
  logic       det_sel;

  int  checks = 0;
  int  errors = 0;
  real rec_ps = 4000.0;

  ppm_lock_detector #(.WIN_LOG2(WL), .TOL_NARROW(TOLN), .TOL_WIDE(TOLW)) u_dut (
    .ref_clk     (ref_clk),
    .rec_clk     (rec_clk),
    .rst_n       (rst_n),
    .mode_sel    (mode_sel),
    .ref_rate_sel(ref_rate_sel),
    .lock_ok     (lock_ok),
    .det_sel     (det_sel)
  );

  always #2 ref_clk = ~ref_clk;

  initial begin
    forever begin
      #(rec_ps / 2000.0);
      rec_clk = ~rec_clk;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_ref(input int n);
    for (int i = 0; i < n; i++) @(posedge ref_clk);
    #1;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    real periods[3];
    rst_n        = 1'b0;
    mode_sel     = 2'b00;
    ref_rate_sel = 1'b1;
    rec_ps       = 4000.0;
    wait_ref(5);
    check("R1 lock_ok in reset", lock_ok, 1'b0);
    check("R1 det_sel in reset", det_sel, 1'b0);
    @(negedge ref_clk);
    rst_n = 1'b1;
    wait_ref(3);
    check("R1 lock_ok after reset", lock_ok, 1'b0);
    check("R1 det_sel after reset", det_sel, 1'b0);
    // R7: first window discarded, two good windows needed: no lock at 2.5 windows
    wait_ref(WIN * 5 / 2 - 3);
    check("R7 no lock after one good window", lock_ok, 1'b0);
    wait_ref(WIN * 3 / 2);
    check("R7 lock after two good windows", lock_ok, 1'b1);
    check("R2 bang-bang when locked", det_sel, 1'b1);
    // R8: a single bad window drops lock
    rec_ps = 3200.0;
    wait_ref(WIN * 2 + 12);
    check("R8 lock dropped", lock_ok, 1'b0);
    check("R2 phase-frequency when unlocked", det_sel, 1'b0);

    // Sweep: rates x modes x frequency patterns
    for (int rate = 0; rate < 2; rate++) begin
      if (rate == 1) begin
        periods[0] = 4000.0; periods[1] = 3710.0; periods[2] = 3200.0;
      end else begin
        periods[0] = 1000.0; periods[1] = 955.0;  periods[2] = 800.0;
      end
      for (int m = 0; m < 4; m++) begin
        for (int p = 0; p < 3; p++) begin
          int  cnt, expc, dev, tol;
          logic lk, dt;
          string tag;
          ref_rate_sel = rate[0];
          mode_sel     = m[1:0];
          rec_ps       = periods[p];
          wait_ref(WIN * 6);
          cnt  = int'(4000.0 * WIN / periods[p] + 0.5);
          expc = (rate == 1) ? WIN : 4 * WIN;
          tol  = (m == 1) ? TOLW : TOLN;
          if (rate == 0) tol = tol * 4;
          dev  = (cnt > expc) ? cnt - expc : expc - cnt;
          lk   = (dev <= tol);
          case (m)
            0: begin tag = "R2"; dt = lk; end
            1: begin tag = "R3"; dt = lk; end
            2: begin tag = "R4"; dt = 1'b0; end
            default: begin tag = "R5"; dt = 1'b1; end
          endcase
          check($sformatf("%s R6 lock_ok rate=%0d pat=%0d", tag, rate, p), lock_ok, lk);
          check($sformatf("%s det_sel rate=%0d pat=%0d", tag, rate, p), det_sel, dt);
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule